// File: doc/BRIEF.md
# Capture and Reload Timer with Clock Output

This block is a 16-bit timer/counter paired with a 16-bit holding register. The holding register is the reload value in some modes and the capture register in others. A run bit, a capture/reload select and two baud-source selects pick one of four behaviours:

- **Off.**
- **Auto-reload.** Counts up, or optionally in both directions with the direction taken from the external control pin.
- **Capture.** A falling edge on the external control pin snapshots the count.
- **Fast.** Covers baud generation and clock output. The counter steps at half the clock rate and rolls over to the holding value. It feeds a divide-by-16 baud tick and a toggling clock pin, and never raises the overflow flag.

Software loads the count and the holding register through write strobes. It reads both values on the outputs. It clears the two event flags with pulse inputs. The two flags are ORed into a single interrupt request. Each serial direction has its own select bit, which routes either this timer's baud tick or an externally supplied tick to that direction's output. The serial port itself lies outside the block.

Top module: `cap_reload_timer`

## Requirements
- R1: With `run_en`=0 the block is off and the count holds. With `run_en`=1, `tx_baud_sel`=`rx_baud_sel`=0 selects auto-reload when `cap_sel`=0 and capture when `cap_sel`=1. Either baud select at 1 selects fast (baud) mode.
- R2: In auto-reload and capture modes with `cnt_sel`=0, the count steps once every 12 clocks of running time; after N clocks it has moved floor(N/12) steps. With `cnt_sel`=1 it steps once per falling edge of `t2_pin` instead.
- R3: In auto-reload mode counting up, a step from FFFFh loads the holding value and sets `ovf_flag`.
- R4: With `dcnt_en`=1 in auto-reload mode, a low `t2ex_pin` counts down and a high one counts up. Counting down, a step taken while the count equals the holding value loads FFFFh and sets `ovf_flag`. With `dcnt_en`=0 the count always goes up.
- R5: In capture mode a step from FFFFh wraps to 0000h and sets `ovf_flag`. The count is never loaded from the holding register.
- R6: In capture mode with `ext_en`=1, a falling edge on `t2ex_pin` copies the current count into the holding register and sets `ext_flag`. The count carries on undisturbed.
- R7: In auto-reload mode with `ext_en`=1 and `dcnt_en`=0, a falling edge on `t2ex_pin` loads the holding value into the count and sets `ext_flag`.
- R8: With `ext_en`=0, edges on `t2ex_pin` change neither the count, nor the holding register, nor `ext_flag`.
- R9: `irq` is high exactly when `ovf_flag` or `ext_flag` is set. `ovf_clr` and `ext_clr` clear their flag, but a flag set in the same cycle as its clear stays set.
- R10: In fast mode (either baud select, or `clko_en`=1 with `cnt_sel`=0, while running), the count steps every 2 clocks. A step from FFFFh loads the holding value, and `ovf_flag` is never set.
- R11: With clock output active (`run_en`=1, `clko_en`=1, `cnt_sel`=0), `clk_out` toggles on each fast rollover, giving a period of 4*(65536-holding) clocks. When inactive, `clk_out` is low.
- R12: The timer's baud tick is a one-clock pulse on every 16th fast rollover in baud mode. `tx_tick` carries it when `tx_baud_sel`=1, otherwise `t1_tx_tick`. `rx_tick` works the same way with `rx_baud_sel` and `t1_rx_tick`.
- R13: A capture edge and an overflow in the same cycle both take effect. The holding register receives the pre-step count FFFFh, the count wraps to 0000h, and both flags are set.
- R14: After reset the count, holding register, flags, `irq`, `clk_out` and the timer's baud tick are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t2_pin | input | 1 | External count input (falling edges) |
| t2ex_pin | input | 1 | External capture/reload edge or direction level |
| run_en | input | 1 | Run |
| cnt_sel | input | 1 | 1: count `t2_pin` edges, 0: internal time base |
| cap_sel | input | 1 | 1: capture, 0: auto-reload |
| ext_en | input | 1 | Enable `t2ex_pin` edge events |
| dcnt_en | input | 1 | Allow down counting under `t2ex_pin` level |
| clko_en | input | 1 | Enable clock output |
| tx_baud_sel | input | 1 | Transmit tick from this timer |
| rx_baud_sel | input | 1 | Receive tick from this timer |
| t1_tx_tick | input | 1 | Alternate transmit tick |
| t1_rx_tick | input | 1 | Alternate receive tick |
| cnt_wr | input | 1 | Load count from `cnt_din` |
| cnt_din | input | 16 | Count write data |
| rld_wr | input | 1 | Load holding register from `rld_din` |
| rld_din | input | 16 | Holding register write data |
| ovf_clr | input | 1 | Clear overflow flag |
| ext_clr | input | 1 | Clear external flag |
| count_q | output | 16 | Current count |
| rld_q | output | 16 | Holding (reload/capture) register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External event flag |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Programmable clock output |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |

## Verification
In capture mode a counting step and a capture edge can land in the same cycle. The tricky case is the step that wraps FFFFh. The bench provokes it with an externally clocked counter preloaded to FFFFh: it drops `t2_pin` and `t2ex_pin` on the same clock, so both synchronised falling edges emerge together. It then expects 0000h in the count, FFFFh in the holding register, and both flags set. A second coincidence is checked as well: a flag clear is pulsed exactly on the cycle the overflow is processed, and the flag must survive.

// File: rtl/crt_pkg.sv
package crt_pkg;

  typedef enum logic [1:0] {
    CRT_OFF     = 2'd0,
    CRT_RELOAD  = 2'd1,
    CRT_CAPTURE = 2'd2,
    CRT_BAUD    = 2'd3
  } crt_mode_e;

  function automatic crt_mode_e crt_decode(input logic run, input logic cap,
                                           input logic txs, input logic rxs);
    crt_mode_e m;
    if (!run)            m = CRT_OFF;
    else if (txs || rxs) m = CRT_BAUD;
    else if (cap)        m = CRT_CAPTURE;
    else                 m = CRT_RELOAD;
    return m;
  endfunction

endpackage

// File: rtl/crt_sync.sv
module crt_sync #(
  parameter int NBITS  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] pin_i,
  output logic [NBITS-1:0] lvl_o
);
  logic [NBITS-1:0] stg_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [NBITS-1:0] stg_d;
      if (gi == 0) begin : g_first
        assign stg_d = pin_i;
      end else begin : g_rest
        assign stg_d = stg_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[gi] <= '1;
        else        stg_q[gi] <= stg_d;
      end
    end
  endgenerate

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/crt_prescale.sv
module crt_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pre_q, pre_d;

  always_comb begin
    if (!run_i)            pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                   pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/crt_count.sv
module crt_count
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  crt_mode_e    mode_i,
  input  logic         fast_i,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         dcnt_en_i,
  input  logic         ext_fall_i,
  input  logic         ext_en_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_din_i,
  input  logic         rld_wr_i,
  input  logic [W-1:0] rld_din_i,
  input  logic         ovf_clr_i,
  input  logic         ext_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         ovf_o,
  output logic         ext_o,
  output logic         roll_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic         ovf_q, ovf_d, ext_q, ext_d;
  logic         ovf_set, ext_set, roll;
  logic         at_top, at_rld, ext_evt;

  assign at_top  = (cnt_q == TOP);
  assign at_rld  = (cnt_q == rld_q);
  assign ext_evt = ext_fall_i && ext_en_i && (mode_i != CRT_OFF);

  always_comb begin
    cnt_d   = cnt_q;
    rld_d   = rld_q;
    ovf_set = 1'b0;
    ext_set = 1'b0;
    roll    = 1'b0;

    if (step_i) begin
      if (fast_i) begin
        roll  = at_top;
        cnt_d = at_top ? rld_q : cnt_q + 1'b1;
      end else begin
        case (mode_i)
          CRT_RELOAD: begin
            if (up_i) begin
              ovf_set = at_top;
              cnt_d   = at_top ? rld_q : cnt_q + 1'b1;
            end else begin
              ovf_set = at_rld;
              cnt_d   = at_rld ? TOP : cnt_q - 1'b1;
            end
          end
          CRT_CAPTURE: begin
            ovf_set = at_top;
            cnt_d   = cnt_q + 1'b1;
          end
          default: cnt_d = cnt_q;
        endcase
      end
    end

    if (ext_evt) begin
      if (fast_i) begin
        ext_set = 1'b1;
      end else if (mode_i == CRT_CAPTURE) begin
        rld_d   = cnt_q;
        ext_set = 1'b1;
      end else if (mode_i == CRT_RELOAD && !dcnt_en_i) begin
        cnt_d   = rld_q;
        ext_set = 1'b1;
      end
    end

    if (rld_wr_i) rld_d = rld_din_i;
    if (cnt_wr_i) cnt_d = cnt_din_i;

    ovf_d = ovf_set || (ovf_q && !ovf_clr_i);
    ext_d = ext_set || (ext_q && !ext_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      ovf_q <= ovf_d;
      ext_q <= ext_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign ovf_o  = ovf_q;
  assign ext_o  = ext_q;
  assign roll_o = roll;
endmodule

// File: rtl/crt_outgen.sv
module crt_outgen #(
  parameter int BAUD_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic roll_i,
  input  logic clko_act_i,
  input  logic baud_act_i,
  input  logic tx_sel_i,
  input  logic rx_sel_i,
  input  logic t1_tx_i,
  input  logic t1_rx_i,
  output logic clk_out_o,
  output logic tx_tick_o,
  output logic rx_tick_o
);
  localparam int BW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [BW-1:0] BLAST = BW'(BAUD_DIV - 1);

  logic          co_q, co_d;
  logic [BW-1:0] div_q, div_d;
  logic          bt_q, bt_d;

  always_comb begin
    co_d  = co_q;
    div_d = div_q;
    bt_d  = 1'b0;
    if (!clko_act_i)  co_d = 1'b0;
    else if (roll_i)  co_d = !co_q;
    if (!baud_act_i) begin
      div_d = '0;
    end else if (roll_i) begin
      bt_d  = (div_q == BLAST);
      div_d = (div_q == BLAST) ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_q  <= 1'b0;
      div_q <= '0;
      bt_q  <= 1'b0;
    end else begin
      co_q  <= co_d;
      div_q <= div_d;
      bt_q  <= bt_d;
    end
  end

  assign clk_out_o = co_q;
  assign tx_tick_o = tx_sel_i ? bt_q : t1_tx_i;
  assign rx_tick_o = rx_sel_i ? bt_q : t1_rx_i;
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int W           = 16,
  parameter int MC_DIV      = 12,
  parameter int FAST_DIV    = 2,
  parameter int BAUD_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         t2_pin,
  input  logic         t2ex_pin,
  input  logic         run_en,
  input  logic         cnt_sel,
  input  logic         cap_sel,
  input  logic         ext_en,
  input  logic         dcnt_en,
  input  logic         clko_en,
  input  logic         tx_baud_sel,
  input  logic         rx_baud_sel,
  input  logic         t1_tx_tick,
  input  logic         t1_rx_tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_din,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_din,
  input  logic         ovf_clr,
  input  logic         ext_clr,
  output logic [W-1:0] count_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_flag,
  output logic         ext_flag,
  output logic         irq,
  output logic         clk_out,
  output logic         tx_tick,
  output logic         rx_tick
);
  localparam int NPINS = 2;

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic [NPINS-1:0] pin_lvl, pin_prev, pin_fall;
  logic             mc_tick, fast_tick, step, up;
  logic             clko_act, fast, roll;
  crt_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  crt_sync #(.NBITS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .pin_i ({t2ex_pin, t2_pin}),
    .lvl_o (pin_lvl)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pin_prev <= '1;
    else             pin_prev <= pin_lvl;
  end
  assign pin_fall = pin_prev & ~pin_lvl;

  assign mode     = crt_decode(run_en, cap_sel, tx_baud_sel, rx_baud_sel);
  assign clko_act = run_en && clko_en && !cnt_sel;
  assign fast     = (mode == CRT_BAUD) || clko_act;

  crt_prescale #(.DIV(MC_DIV)) u_mc_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_i  (run_en),
    .tick_o (mc_tick)
  );

  crt_prescale #(.DIV(FAST_DIV)) u_fast_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .run_i  (run_en),
    .tick_o (fast_tick)
  );

  always_comb begin
    if (cnt_sel)   step = run_en && pin_fall[0];
    else if (fast) step = fast_tick;
    else           step = mc_tick;
  end

  assign up = !dcnt_en || pin_lvl[1];

  crt_count #(.W(W)) u_count (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .mode_i     (mode),
    .fast_i     (fast),
    .step_i     (step),
    .up_i       (up),
    .dcnt_en_i  (dcnt_en),
    .ext_fall_i (pin_fall[1]),
    .ext_en_i   (ext_en),
    .cnt_wr_i   (cnt_wr),
    .cnt_din_i  (cnt_din),
    .rld_wr_i   (rld_wr),
    .rld_din_i  (rld_din),
    .ovf_clr_i  (ovf_clr),
    .ext_clr_i  (ext_clr),
    .cnt_o      (count_q),
    .rld_o      (rld_q),
    .ovf_o      (ovf_flag),
    .ext_o      (ext_flag),
    .roll_o     (roll)
  );

  crt_outgen #(.BAUD_DIV(BAUD_DIV)) u_outgen (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .roll_i     (roll),
    .clko_act_i (clko_act),
    .baud_act_i (mode == CRT_BAUD),
    .tx_sel_i   (tx_baud_sel),
    .rx_sel_i   (rx_baud_sel),
    .t1_tx_i    (t1_tx_tick),
    .t1_rx_i    (t1_rx_tick),
    .clk_out_o  (clk_out),
    .tx_tick_o  (tx_tick),
    .rx_tick_o  (rx_tick)
  );

  assign irq = ovf_flag || ext_flag;
endmodule

// File: rtl/cap_reload_timer_chk.sv
module cap_reload_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_core_n,
  input logic         run_en,
  input logic         cnt_sel,
  input logic         cap_sel,
  input logic         clko_en,
  input logic         tx_baud_sel,
  input logic         rx_baud_sel,
  input logic         cnt_wr,
  input logic [W-1:0] count_q,
  input logic         ovf_flag,
  input logic         ext_flag,
  input logic         irq,
  input logic         clk_out
);
  logic fast_c, cap_c;
  assign fast_c = run_en && (tx_baud_sel || rx_baud_sel || (clko_en && !cnt_sel));
  assign cap_c  = run_en && cap_sel && !fast_c;

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!run_en && !cnt_wr) |=> $stable(count_q)); // R1

  AST_CAPTURE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cap_c && !cnt_wr) |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R5

  AST_FAST_NO_OVF: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fast_c && !ovf_flag) |=> !ovf_flag); // R10

  AST_CLKOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(run_en && clko_en && !cnt_sel) |=> !clk_out); // R11

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($rose(ovf_flag) || $rose(ext_flag)) |-> irq); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ovf_flag && !ext_flag) |-> !irq); // R9
endmodule

bind cap_reload_timer cap_reload_timer_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .run_en      (run_en),
  .cnt_sel     (cnt_sel),
  .cap_sel     (cap_sel),
  .clko_en     (clko_en),
  .tx_baud_sel (tx_baud_sel),
  .rx_baud_sel (rx_baud_sel),
  .cnt_wr      (cnt_wr),
  .count_q     (count_q),
  .ovf_flag    (ovf_flag),
  .ext_flag    (ext_flag),
  .irq         (irq),
  .clk_out     (clk_out)
);

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        t2_pin, t2ex_pin, run_en, cnt_sel, cap_sel, ext_en, dcnt_en, clko_en;
  logic        tx_baud_sel, rx_baud_sel, t1_tx_tick, t1_rx_tick;
  logic        cnt_wr, rld_wr, ovf_clr, ext_clr;
  logic [15:0] cnt_din, rld_din, count_q, rld_q;
  logic        ovf_flag, ext_flag, irq, clk_out, tx_tick, rx_tick;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cap_reload_timer u_cap_reload_timer (
    .clk(clk), .rst_n(rst_n), .t2_pin(t2_pin), .t2ex_pin(t2ex_pin),
    .run_en(run_en), .cnt_sel(cnt_sel), .cap_sel(cap_sel), .ext_en(ext_en),
    .dcnt_en(dcnt_en), .clko_en(clko_en), .tx_baud_sel(tx_baud_sel),
    .rx_baud_sel(rx_baud_sel), .t1_tx_tick(t1_tx_tick), .t1_rx_tick(t1_rx_tick),
    .cnt_wr(cnt_wr), .cnt_din(cnt_din), .rld_wr(rld_wr), .rld_din(rld_din),
    .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count_q(count_q), .rld_q(rld_q),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .clk_out(clk_out),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  typedef struct packed {
    logic        cnt_s, cap_s, dcnt, clko, txs, rxs, run, t2ex;
    logic [15:0] rld, start;
    logic [7:0]  ncyc;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h1234, 16'hFFFE, 8'd36, 16'h1235, 1'b1}, // R3
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h4444, 16'hFFFE, 8'd36, 16'h0001, 1'b1}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h0000, 16'h0010, 8'd60, 16'h0015, 1'b0}, // R2
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0100, 16'h0102, 8'd36, 16'hFFFF, 1'b1}, // R4 down
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h0200, 16'hFFFF, 8'd12, 16'h0200, 1'b1}, // R4 up
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 16'h0300, 16'h0010, 8'd24, 16'h0012, 1'b0}, // R4 dcnt off
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 16'hFFF0, 16'hFFF0, 8'd40, 16'hFFF4, 1'b0}, // R10 baud
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 16'h8000, 16'hFFFE, 8'd4,  16'h8000, 1'b0}, // R10 clkout
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'h0000, 16'h0055, 8'd24, 16'h0055, 1'b0}  // R1 off
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle_cfg();
    run_en = 0; cnt_sel = 0; cap_sel = 0; ext_en = 0; dcnt_en = 0; clko_en = 0;
    tx_baud_sel = 0; rx_baud_sel = 0;
  endtask

  task automatic setup(input logic [15:0] st, input logic [15:0] rv);
    @(negedge clk);
    idle_cfg();
    cnt_wr = 1; cnt_din = st; rld_wr = 1; rld_din = rv; ovf_clr = 1; ext_clr = 1;
    @(negedge clk);
    cnt_wr = 0; rld_wr = 0; ovf_clr = 0; ext_clr = 0;
    repeat (4) @(negedge clk);
  endtask

  logic mon_en = 1'b0;
  logic co_prev = 1'b0;
  int   co_rises = 0, tx_cnt = 0, rx_cnt = 0;
  always @(posedge clk) begin
    co_prev <= clk_out;
    if (mon_en) begin
      if (clk_out && !co_prev) co_rises <= co_rises + 1;
      if (tx_tick) tx_cnt <= tx_cnt + 1;
      if (rx_tick) rx_cnt <= rx_cnt + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; t2_pin = 1; t2ex_pin = 1; t1_tx_tick = 0; t1_rx_tick = 0;
    cnt_wr = 0; rld_wr = 0; cnt_din = 0; rld_din = 0; ovf_clr = 0; ext_clr = 0;
    idle_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R14 reset state
    chk("R14 count", count_q, 0);
    chk("R14 hold", rld_q, 0);
    chk("R14 flags", {ovf_flag, ext_flag, irq}, 0);
    chk("R14 clk_out/tick", {clk_out, tx_tick}, 0);

    // Vector table: modes, rates, rollovers
    for (int i = 0; i < NVEC; i++) begin
      t2ex_pin = VEC[i].t2ex;
      setup(VEC[i].start, VEC[i].rld);
      {cnt_sel, cap_sel, dcnt_en, clko_en, tx_baud_sel, rx_baud_sel, run_en} =
        {VEC[i].cnt_s, VEC[i].cap_s, VEC[i].dcnt, VEC[i].clko, VEC[i].txs, VEC[i].rxs, VEC[i].run};
      repeat (int'(VEC[i].ncyc)) @(negedge clk);
      chk($sformatf("R1/R2/R3/R4/R5/R10 vec%0d count", i), count_q, VEC[i].exp_cnt);
      chk($sformatf("R3/R4/R5/R10 vec%0d ovf", i), ovf_flag, VEC[i].exp_ovf);
      idle_cfg();
    end
    t2ex_pin = 1;

    // R6 capture on t2ex fall, counter frozen (external clock static)
    setup(16'h0123, 16'h0000);
    cap_sel = 1; cnt_sel = 1; ext_en = 1; run_en = 1;
    repeat (2) @(negedge clk);
    t2ex_pin = 0;
    repeat (5) @(negedge clk);
    chk("R6 hold captured", rld_q, 16'h0123);
    chk("R6 count kept", count_q, 16'h0123);
    chk("R6 ext_flag", ext_flag, 1);
    chk("R9 irq from ext", irq, 1);
    ext_clr = 1; @(negedge clk); ext_clr = 0;
    chk("R9 ext cleared irq low", {ext_flag, irq}, 0);
    t2ex_pin = 1;

    // R8 edges ignored with ext_en=0
    setup(16'h0300, 16'h0ABC);
    cnt_sel = 1; run_en = 1;
    repeat (2) @(negedge clk);
    t2ex_pin = 0;
    repeat (5) @(negedge clk);
    chk("R8 count", count_q, 16'h0300);
    chk("R8 hold", rld_q, 16'h0ABC);
    chk("R8 ext_flag", ext_flag, 0);
    t2ex_pin = 1;

    // R7 forced reload
    setup(16'h0300, 16'h0ABC);
    cnt_sel = 1; ext_en = 1; run_en = 1;
    repeat (2) @(negedge clk);
    t2ex_pin = 0;
    repeat (5) @(negedge clk);
    chk("R7 count reloaded", count_q, 16'h0ABC);
    chk("R7 ext_flag", ext_flag, 1);
    t2ex_pin = 1;

    // R2 external count edges
    setup(16'h0010, 16'h0000);
    cnt_sel = 1; run_en = 1;
    for (int k = 0; k < 5; k++) begin
      t2_pin = 0; repeat (3) @(negedge clk);
      t2_pin = 1; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R2 external count", count_q, 16'h0015);

    // R13 capture and overflow in the same cycle
    setup(16'hFFFF, 16'h1111);
    cap_sel = 1; cnt_sel = 1; ext_en = 1; run_en = 1;
    repeat (2) @(negedge clk);
    t2_pin = 0; t2ex_pin = 0;
    repeat (5) @(negedge clk);
    chk("R13 count wrapped", count_q, 16'h0000);
    chk("R13 hold got pre-step", rld_q, 16'hFFFF);
    chk("R13 both flags", {ovf_flag, ext_flag}, 2'b11);
    t2_pin = 1; t2ex_pin = 1;

    // R9 set wins over a coincident clear
    setup(16'hFFFF, 16'h0000);
    cap_sel = 1; cnt_sel = 1; run_en = 1;
    repeat (3) @(negedge clk);
    t2_pin = 0;
    repeat (2) @(negedge clk);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    chk("R9 set beats clear", ovf_flag, 1);
    t2_pin = 1;

    // R11 clock output period 4*(65536-FFFEh)=8 clocks
    setup(16'hFFFE, 16'hFFFE);
    clko_en = 1; run_en = 1;
    repeat (4) @(negedge clk);
    mon_en = 1; co_rises = 0;
    repeat (400) @(negedge clk);
    mon_en = 0;
    chk_rng("R11 clk_out rises", co_rises, 49, 50);
    chk("R10 no ovf in clock-out", ovf_flag, 0);
    run_en = 0;
    repeat (2) @(negedge clk);
    chk("R11 clk_out low when idle", clk_out, 0);

    // R12 baud tick every 16 rollovers (64 clocks), rx from alternate source
    setup(16'hFFFE, 16'hFFFE);
    tx_baud_sel = 1; run_en = 1;
    tx_cnt = 0; rx_cnt = 0; mon_en = 1;
    for (int k = 0; k < 640; k++) begin
      t1_rx_tick = (k == 100 || k == 300 || k == 500);
      @(negedge clk);
    end
    t1_rx_tick = 0;
    mon_en = 0;
    chk_rng("R12 tx ticks", tx_cnt, 9, 10);
    chk("R12 rx from alternate", rx_cnt, 3);
    chk("R10 no ovf in baud", ovf_flag, 0);
    idle_cfg();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule